// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the software-facing half of a serial port. A simple 32-bit read/write bus reaches six word registers: a transmit queue write port, a receive queue read port, control, status, interrupt thresholds and baud configuration. Behind them sit a 64-entry transmit queue and a 64-entry receive queue of bytes. Each queue talks to its own serializer engine over a byte-wide valid/ready handshake.

Control bits enable each direction, flush each queue and clear the latched error flags. None of these bits clears itself. Each acts for as long as it reads 1, and software writes it back to 0 afterwards. The receiver reports parity and framing errors as single-cycle pulses, and the block latches them. A single interrupt line combines a receive-fill condition and a transmit-drain condition, each compared against its own programmable threshold. The control word and the baud field are passed out to the framing and baud-timing logic, which sits outside this block.

A bus read returns its data on `bus_rdata_o` one clock after the request cycle. A read of the receive port in that request cycle removes the oldest byte.

Top module: `serial_regfile`

## Requirements
- R1: After reset the control, threshold and baud registers hold zero. Status reads 0x0050_0000, which is receive empty (bit 20) plus transmit empty (bit 22). `irq_o`, `tx_valid_o` and `rx_ready_o` are low.
- R2: Register offsets are 0x08 for control (all 32 bits), 0x10 for thresholds (bits 15:0 kept, the rest read 0) and 0x14 for baud (bits 23:0 kept). `ctrl_o` and `baud_o` mirror the stored values.
- R3: Writes to 0x00 enter the transmit queue in order. While control bit 12 is 1 the oldest byte is shown on `tx_data_o` with `tx_valid_o`, and it leaves the queue on a cycle with `tx_valid_o` and `tx_ready_i` both high. Status bit 21 means the queue holds 64 bytes.
- R4: A write to 0x00 while the transmit queue is full is dropped, and it sets status bit 18.
- R5: `rx_ready_o` is high only when control bit 13 is 1 and the receive queue is not full. A read of 0x04 returns the oldest received byte in bits 7:0 and removes it. Status bit 20 means the receive queue is empty.
- R6: A read of 0x04 while the receive queue is empty returns 0 and leaves the queue and status unchanged.
- R7: While control bit 22 is 1 the transmit queue is held empty. While control bit 23 is 1 the receive queue is held empty and `rx_ready_o` is low.
- R8: Status bits 16 (parity) and 17 (framing) are set by pulses on `rx_par_err_i` and `rx_frm_err_i` and stay set. Bits 16, 17 and 18 are cleared, and held clear, for as long as control bit 24 is 1.
- R9: Status bit 25 reports `tx_busy_i`. The transmitter is idle only when bit 22 is 1 and bit 25 is 0.
- R10: The receive interrupt is active when control bit 27 is 1 and the receive count is at least threshold bits 7:0.
- R11: The transmit interrupt is active when control bit 28 is 1 and the transmit count is below threshold bits 15:8. `irq_o` is the OR of the two interrupt conditions.
- R12: A receive push and a bus pop in the same cycle leave the receive count unchanged and keep byte order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered |
| tx_data_o | output | 8 | Byte to the transmit engine |
| tx_valid_o | output | 1 | Transmit byte available |
| tx_ready_i | input | 1 | Transmit engine takes the byte |
| tx_busy_i | input | 1 | Transmit shifter is active |
| rx_data_i | input | 8 | Byte from the receive engine |
| rx_valid_i | input | 1 | Received byte offered |
| rx_ready_o | output | 1 | Receive queue accepts the byte |
| rx_par_err_i | input | 1 | Parity error pulse |
| rx_frm_err_i | input | 1 | Framing error pulse |
| ctrl_o | output | 32 | Control word to the engines |
| baud_o | output | 24 | Baud configuration to the engines |
| irq_o | output | 1 | Interrupt request |

## Verification
Two cases can land in the same cycle. In the first, the receive engine delivers a byte in the same cycle that the bus reads the receive port. The bench provokes this with the queue one short of full, driving both the push and the read between the same pair of clock edges. It then judges the result by draining the queue: every earlier byte must come out in order, the new byte must come last, and the queue must end empty. In the second, errors collide with the clear bit: a parity pulse that arrives while the clear bit is held must stay invisible, both during the hold and after the clear bit is released.

// File: rtl/serial_regfile_pkg.sv
package serial_regfile_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_TXQ  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_RXQ  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_STAT = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_THR  = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_BAUD = 5'h14;

  // control bit positions
  localparam int unsigned C_TX_EN   = 12;
  localparam int unsigned C_RX_EN   = 13;
  localparam int unsigned C_TX_RST  = 22;
  localparam int unsigned C_RX_RST  = 23;
  localparam int unsigned C_ERR_CLR = 24;
  localparam int unsigned C_RX_IE   = 27;
  localparam int unsigned C_TX_IE   = 28;

  // status bit positions
  localparam int unsigned S_PAR    = 16;
  localparam int unsigned S_FRM    = 17;
  localparam int unsigned S_WERR   = 18;
  localparam int unsigned S_RX_EMP = 20;
  localparam int unsigned S_TX_FUL = 21;
  localparam int unsigned S_TX_EMP = 22;
  localparam int unsigned S_TX_BSY = 25;

  localparam int unsigned NUM_ERR = 3;
  typedef enum logic [1:0] {ERR_PAR = 2'd0, ERR_FRM = 2'd1, ERR_WERR = 2'd2} err_idx_e;
endpackage

// File: rtl/serial_fifo.sv
module serial_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [W-1:0]  pdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full_o  = (cnt == CW'(DEPTH));
  assign empty_o = (cnt == '0);
  assign count_o = cnt;
  assign head_o  = mem[rd_ptr];
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= step(wr_ptr);
      if (pop_ok)  rd_ptr <= step(rd_ptr);
      cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok && !flush_i) mem[wr_ptr] <= pdata_i;
  end

  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));
  a_r3_push_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !full_o && !flush_i) |=> count_o == $past(count_o) + CW'(1));
  a_r12_push_pop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !full_o && !empty_o && !flush_i) |=> $stable(count_o));
  a_r7_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/serial_err_track.sv
module serial_err_track #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_o[g] <= 1'b0;
      else if (clr_i)    flag_o[g] <= 1'b0;   // level-held clear wins
      else if (set_i[g]) flag_o[g] <= 1'b1;
    end

    a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o[g] && !clr_i) |=> flag_o[g]);
    a_r8_clear_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> !flag_o[g]);
    a_r8_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i[g] && !clr_i) |=> flag_o[g]);
  end
endmodule

// File: rtl/serial_irq_gen.sv
module serial_irq_gen #(
  parameter int unsigned CW = 7,
  parameter int unsigned TW = 8
) (
  input  logic [CW-1:0] rx_cnt_i,
  input  logic [CW-1:0] tx_cnt_i,
  input  logic [TW-1:0] rx_thr_i,
  input  logic [TW-1:0] tx_thr_i,
  input  logic          rx_ie_i,
  input  logic          tx_ie_i,
  output logic          irq_o
);
  logic rx_hit, tx_hit;
  assign rx_hit = rx_ie_i && (32'(rx_cnt_i) >= 32'(rx_thr_i));
  assign tx_hit = tx_ie_i && (32'(tx_cnt_i) <  32'(tx_thr_i));
  assign irq_o  = rx_hit || tx_hit;
endmodule

// File: rtl/serial_regfile.sv
module serial_regfile
  import serial_regfile_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned BAUD_W = 24,
  parameter int unsigned THR_W  = 8,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [4:0]        bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  input  logic              tx_busy_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  input  logic              rx_par_err_i,
  input  logic              rx_frm_err_i,
  output logic [31:0]       ctrl_o,
  output logic [BAUD_W-1:0] baud_o,
  output logic              irq_o
);
  localparam int unsigned THR_BITS = 2 * THR_W;

  logic [DATA_W-1:0]   ctrl_q;
  logic [THR_BITS-1:0] thr_q;
  logic [BAUD_W-1:0]   baud_q;

  logic bus_wr, bus_rd;
  logic tx_push, tx_pop, tx_full, tx_empty, tx_rst, tx_wr_err;
  logic rx_push, rx_pop, rx_full, rx_empty, rx_rst;
  logic [7:0]    rx_head;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [NUM_ERR-1:0] err_set, err_flag;
  logic [DATA_W-1:0]  status, rd_mux;

  assign bus_wr = bus_req_i && bus_we_i;
  assign bus_rd = bus_req_i && !bus_we_i;
  assign tx_rst = ctrl_q[C_TX_RST];
  assign rx_rst = ctrl_q[C_RX_RST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      thr_q  <= '0;
      baud_q <= '0;
    end else if (bus_wr) begin
      unique case (bus_addr_i)
        OFS_CTRL: ctrl_q <= bus_wdata_i;
        OFS_THR:  thr_q  <= bus_wdata_i[THR_BITS-1:0];
        OFS_BAUD: baud_q <= bus_wdata_i[BAUD_W-1:0];
        default: ;
      endcase
    end
  end

  // transmit side
  assign tx_push    = bus_wr && (bus_addr_i == OFS_TXQ);
  assign tx_wr_err  = tx_push && tx_full && !tx_rst;
  assign tx_valid_o = ctrl_q[C_TX_EN] && !tx_empty && !tx_rst;
  assign tx_pop     = tx_valid_o && tx_ready_i;

  serial_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk_i, .rst_ni,
    .flush_i (tx_rst),
    .push_i  (tx_push),
    .pdata_i (bus_wdata_i[7:0]),
    .pop_i   (tx_pop),
    .head_o  (tx_data_o),
    .count_o (tx_cnt),
    .full_o  (tx_full),
    .empty_o (tx_empty)
  );

  // receive side
  assign rx_ready_o = ctrl_q[C_RX_EN] && !rx_full && !rx_rst;
  assign rx_push    = rx_valid_i && rx_ready_o;
  assign rx_pop     = bus_rd && (bus_addr_i == OFS_RXQ);

  serial_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
    .clk_i, .rst_ni,
    .flush_i (rx_rst),
    .push_i  (rx_push),
    .pdata_i (rx_data_i),
    .pop_i   (rx_pop),
    .head_o  (rx_head),
    .count_o (rx_cnt),
    .full_o  (rx_full),
    .empty_o (rx_empty)
  );

  // error flags
  always_comb begin
    err_set           = '0;
    err_set[ERR_PAR]  = rx_par_err_i;
    err_set[ERR_FRM]  = rx_frm_err_i;
    err_set[ERR_WERR] = tx_wr_err;
  end

  serial_err_track #(.N(NUM_ERR)) u_err (
    .clk_i, .rst_ni,
    .clr_i  (ctrl_q[C_ERR_CLR]),
    .set_i  (err_set),
    .flag_o (err_flag)
  );

  serial_irq_gen #(.CW(CW), .TW(THR_W)) u_irq (
    .rx_cnt_i (rx_cnt),
    .tx_cnt_i (tx_cnt),
    .rx_thr_i (thr_q[THR_W-1:0]),
    .tx_thr_i (thr_q[THR_BITS-1:THR_W]),
    .rx_ie_i  (ctrl_q[C_RX_IE]),
    .tx_ie_i  (ctrl_q[C_TX_IE]),
    .irq_o    (irq_o)
  );

  always_comb begin
    status           = '0;
    status[S_PAR]    = err_flag[ERR_PAR];
    status[S_FRM]    = err_flag[ERR_FRM];
    status[S_WERR]   = err_flag[ERR_WERR];
    status[S_RX_EMP] = rx_empty;
    status[S_TX_FUL] = tx_full;
    status[S_TX_EMP] = tx_empty;
    status[S_TX_BSY] = tx_busy_i;
  end

  always_comb begin
    rd_mux = '0;
    unique case (bus_addr_i)
      OFS_RXQ:  rd_mux = rx_empty ? '0 : DATA_W'(rx_head);
      OFS_CTRL: rd_mux = ctrl_q;
      OFS_STAT: rd_mux = status;
      OFS_THR:  rd_mux = DATA_W'(thr_q);
      OFS_BAUD: rd_mux = DATA_W'(baud_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bus_rdata_o <= '0;
    else if (bus_rd) bus_rdata_o <= rd_mux;
  end

  assign ctrl_o = ctrl_q;
  assign baud_o = baud_q;

  a_r4_full_write_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_push && tx_full && !tx_rst && !ctrl_q[C_ERR_CLR]) |=> err_flag[ERR_WERR]);
  a_r6_empty_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_pop && rx_empty) |=> bus_rdata_o == '0);
  a_r5_rx_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q[C_RX_EN] |-> !rx_ready_o);
  a_r7_rx_reset_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_rst |-> !rx_ready_o);
  a_r3_tx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i && !bus_wr) |=> tx_valid_o && $stable(tx_data_o));
endmodule

// File: tb/serial_regfile_tb.sv
module serial_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 0, we = 0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_ready = 0, tx_busy = 0;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 0, rx_ready;
  logic        par_err = 0, frm_err = 0;
  logic [31:0] ctrl;
  logic [23:0] baud;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  serial_regfile u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_busy_i(tx_busy),
    .rx_data_i(rx_data), .rx_valid_i(rx_valid), .rx_ready_o(rx_ready),
    .rx_par_err_i(par_err), .rx_frm_err_i(frm_err),
    .ctrl_o(ctrl), .baud_o(baud), .irq_o(irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    @(negedge clk);
    req = 0;
    d = rdata;
  endtask

  task automatic rx_push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1; rx_data = b;
    @(negedge clk);
    rx_valid = 0;
  endtask

  function automatic logic [7:0] rxb(input int i);
    return 8'(i) ^ 8'h5A;
  endfunction

  initial begin
    #(500us);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(5'h0C, v); chk(v, 32'h0050_0000, "R1 status");
    rd(5'h08, v); chk(v, 0, "R1 ctrl");
    chk({31'b0, irq}, 0, "R1 irq");
    chk({30'b0, tx_valid, rx_ready}, 0, "R1 handshakes");

    // R2 register map
    wr(5'h10, 32'hABCD_1234); rd(5'h10, v); chk(v, 32'h0000_1234, "R2 thr");
    wr(5'h14, 32'hFFFF_FFFF); rd(5'h14, v); chk(v, 32'h00FF_FFFF, "R2 baud");
    chk({8'b0, baud}, 32'h00FF_FFFF, "R2 baud_o");
    wr(5'h08, 32'h0003_0000); rd(5'h08, v); chk(v, 32'h0003_0000, "R2 ctrl");
    chk(ctrl, 32'h0003_0000, "R2 ctrl_o");

    // R11 sweep transmit fill against threshold 32, R3 fill to 64
    wr(5'h10, 32'h0000_2000);
    wr(5'h08, 32'h1000_0000);
    tx_ready = 1;
    for (int i = 0; i <= 64; i++) begin
      chk({31'b0, irq}, {31'b0, (i < 32)}, "R11 tx irq vs count");
      if (i < 64) wr(5'h00, 32'(i));
    end
    chk({31'b0, tx_valid}, 0, "R3 held while disabled");
    rd(5'h0C, v); chk(v & 32'h0060_0000, 32'h0020_0000, "R3 full flag");
    chk(v & 32'h0004_0000, 0, "R4 no error before overflow");
    wr(5'h00, 32'hEE);
    rd(5'h0C, v); chk(v & 32'h0004_0000, 32'h0004_0000, "R4 write-error flag");
    wr(5'h08, 32'h1000_1000);
    for (int k = 0; k < 64; k++) begin
      chk({23'b0, tx_valid, tx_data}, {23'b0, 1'b1, 8'(k)}, "R3 drain order");
      @(negedge clk);
    end
    chk({31'b0, tx_valid}, 0, "R4 dropped byte absent");
    rd(5'h0C, v); chk(v & 32'h0060_0000, 32'h0040_0000, "R3 empty after drain");

    // R8 clear of the write error
    wr(5'h08, 32'h0100_0000);
    rd(5'h0C, v); chk(v & 32'h0007_0000, 0, "R8 clear write error");
    wr(5'h08, 32'h0);

    // R9 busy reporting
    tx_busy = 1;
    rd(5'h0C, v); chk(v & 32'h0240_0000, 32'h0240_0000, "R9 busy with empty queue");
    tx_busy = 0;
    rd(5'h0C, v); chk(v & 32'h0240_0000, 32'h0040_0000, "R9 idle");

    // R5 / R10 receive fill sweep with threshold 3
    wr(5'h10, 32'h0000_0003);
    wr(5'h08, 32'h0800_2000);
    for (int i = 0; i <= 64; i++) begin
      chk({31'b0, irq}, {31'b0, (i >= 3)}, "R10 rx irq vs count");
      chk({31'b0, rx_ready}, {31'b0, (i < 64)}, "R5 rx_ready vs count");
      if (i < 64) rx_push(rxb(i));
    end
    rd(5'h04, v); chk(v, {24'b0, rxb(0)}, "R5 first byte");

    // R12 push and pop in one cycle at count 63
    @(negedge clk);
    rx_valid = 1; rx_data = 8'h77; req = 1; we = 0; addr = 5'h04;
    @(negedge clk);
    rx_valid = 0; req = 0;
    chk(rdata, {24'b0, rxb(1)}, "R12 popped byte");
    for (int i = 2; i < 64; i++) begin
      rd(5'h04, v); chk(v, {24'b0, rxb(i)}, "R12 order kept");
    end
    rd(5'h0C, v); chk(v & 32'h0010_0000, 0, "R12 pushed byte still held");
    rd(5'h04, v); chk(v, 32'h77, "R12 pushed byte last");
    rd(5'h0C, v); chk(v & 32'h0010_0000, 32'h0010_0000, "R5 empty flag");

    // R6 empty read
    rd(5'h04, v); chk(v, 0, "R6 empty read zero");
    rd(5'h0C, v); chk(v, 32'h0050_0000, "R6 status unchanged");
    rx_push(8'h33);
    rd(5'h04, v); chk(v, 32'h33, "R6 queue intact after empty read");

    // R8 sticky errors
    @(negedge clk); par_err = 1; @(negedge clk); par_err = 0;
    repeat (4) @(negedge clk);
    rd(5'h0C, v); chk(v & 32'h0007_0000, 32'h0001_0000, "R8 parity sticky");
    @(negedge clk); frm_err = 1; @(negedge clk); frm_err = 0;
    rd(5'h0C, v); chk(v & 32'h0007_0000, 32'h0003_0000, "R8 framing sticky");
    wr(5'h08, 32'h0100_2000);
    rd(5'h0C, v); chk(v & 32'h0007_0000, 0, "R8 cleared");
    @(negedge clk); par_err = 1; @(negedge clk); par_err = 0;
    rd(5'h0C, v); chk(v & 32'h0007_0000, 0, "R8 held clear");
    wr(5'h08, 32'h0000_2000);
    rd(5'h0C, v); chk(v & 32'h0007_0000, 0, "R8 stays clear after release");

    // R7 queue resets
    rx_push(8'h01); rx_push(8'h02);
    wr(5'h08, 32'h0080_2000);
    chk({31'b0, rx_ready}, 0, "R7 rx_ready low in reset");
    rd(5'h0C, v); chk(v & 32'h0010_0000, 32'h0010_0000, "R7 rx flushed");
    wr(5'h08, 32'h0040_0000);
    wr(5'h00, 32'h11);
    rd(5'h0C, v); chk(v & 32'h0040_0000, 32'h0040_0000, "R7 tx held empty");
    wr(5'h08, 32'h0000_1000);
    chk({31'b0, tx_valid}, 0, "R7 nothing queued after release");
    rd(5'h04, v); chk(v, 0, "R7 rx empty after release");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule